// File: doc/BRIEF.md
# Cascaded Two-Stage Free-Running Time Base

This block is a wide free-running time base made of two half-width counter stages. The low stage advances once every few system clocks, at a rate picked by a prescaler select input. While it counts, the low stage drives a square-wave link signal. The link goes high when the low count passes through zero and low when the count reaches its midpoint, so it makes one rising edge per low-half wrap. The upper stage counts rising edges of that link, taken inside the block clock domain. It advances on the same clock edge on which the low half wraps, so the combined value never steps backwards.

A single-cycle sync input clears the prescaler and both stages together. A small read port returns the count without tearing, in one of two ways. Software can read the full combined value in a single access. It can also read the low half, which captures the upper half at that instant, and then fetch the captured upper half later. A build-time option swaps the two stages for one native full-width counter. In that build the link is unused and stays low.

Top module: `cascade_timebase`

## Requirements
- R1: On reset or on a sync pulse, the prescaler and both counter stages clear together on the same edge, and the link output is 1 (the low count is zero). Reads return 0 until the first tick.
- R2: The low stage advances by one on every tick. A tick occurs once every DIV clocks, with DIV = 2 << (2*psel): psel 0,1,2,3 gives 2,8,32,128. The count therefore equals floor(edges since sync / DIV).
- R3: In the chained build, link_o is 1 exactly while the low half's most significant bit is 0. It rises when the low count wraps to 0 and falls when the count reaches the midpoint value.
- R4: The upper half increments by one only on a rising edge of the link, on the same edge the low half wraps. The combined value {upper, low} always equals the tick count modulo 2^(2*HALF_W).
- R5: A sync issued while the count is running restarts the count and the prescaler phase from zero. Counting then proceeds as in R2.
- R6: A read request is answered on the next cycle with rd_valid high for one cycle. With rd_sel = 2 or 3, rd_data is the full combined value as it stood when the request was sampled.
- R7: With rd_sel = 0, rd_data is the low half zero-extended, and the upper half is captured at that same instant. With rd_sel = 1, rd_data is that captured upper half zero-extended, whatever the counter has done since.
- R8: With WIDE = 1, one full-width counter replaces the two stages. Reads, sync and tick rate behave identically, and link_o is held at 0.
- R9: After exactly 2^(2*HALF_W) ticks the combined value returns to 0 and counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sync | input | 1 | Single-cycle command clearing every stage at once |
| psel | input | PSEL_W | Prescaler select; divide ratio 2 << (2*psel) |
| rd_req | input | 1 | Read request, one cycle |
| rd_sel | input | 2 | 0: low half plus capture, 1: captured upper, 2/3: full value |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| rd_data | output | 2*HALF_W | Read data |
| link_o | output | 1 | Link square wave from the low stage to the upper stage |

## Verification
The bench sweeps every prescaler setting on a narrow build, across a complete wrap of the combined count, against arithmetic floor(edges/DIV). A design that let the upper stage trail the low wrap by a cycle would show a value that drops by almost one low-half span at each wrap. A wrong prescaler limit would drift from the edge count. Reading the captured upper half after the counter has moved on exposes a capture that is live or taken at the wrong access. A sync issued mid-run, and the native-width build driven in parallel, catch a stage or a prescaler phase that is left uncleared.

// File: rtl/cascade_timebase.sv
module cascade_timebase #(
  parameter int HALF_W = 16,
  parameter int PSEL_W = 2,
  parameter bit WIDE   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sync,
  input  logic [PSEL_W-1:0]     psel,
  input  logic                  rd_req,
  input  logic [1:0]            rd_sel,
  output logic                  rd_valid,
  output logic [2*HALF_W-1:0]   rd_data,
  output logic                  link_o
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int PRE_W  = 2 * ((1 << PSEL_W) - 1) + 1;

  logic [PRE_W-1:0]  pre_q, pre_lim;
  logic              tick;
  logic [FULL_W-1:0] now_val;
  logic [HALF_W-1:0] hold_q;

  assign pre_lim = {PRE_W{1'b1}} >> (PRE_W - 1 - 2 * int'(psel));
  assign tick    = pre_q >= pre_lim;

  always_ff @(posedge clk) begin
    if (rst || sync)  pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  generate
    if (WIDE) begin : g_wide
      logic [FULL_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || sync) cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
      end
      assign now_val = cnt_q;
      assign link_o  = 1'b0;

      // R8
      wide_link_low_chk: assert property (@(posedge clk) disable iff (rst) link_o == 1'b0);
      // R1
      wide_sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sync |=> cnt_q == '0);
    end else begin : g_chain
      localparam logic [HALF_W-1:0] MID = {1'b1, {(HALF_W-1){1'b0}}};
      logic [HALF_W-1:0] lo_q, hi_q, lo_d;
      logic link_q, link_d, link_rise;

      assign lo_d = lo_q + 1'b1;

      always_comb begin
        link_d = link_q;
        if (tick && lo_d == '0)       link_d = 1'b1;
        else if (tick && lo_d == MID) link_d = 1'b0;
      end
      assign link_rise = link_d & ~link_q;

      always_ff @(posedge clk) begin
        if (rst || sync) begin
          lo_q   <= '0;
          hi_q   <= '0;
          link_q <= 1'b1;
        end else begin
          if (tick)      lo_q <= lo_d;
          link_q <= link_d;
          if (link_rise) hi_q <= hi_q + 1'b1;
        end
      end

      assign now_val = {hi_q, lo_q};
      assign link_o  = link_q;

      // R3
      link_shape_chk: assert property (@(posedge clk) disable iff (rst)
        link_q == !lo_q[HALF_W-1]);
      // R4
      hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync && !(tick && lo_q == '1)) |=> $stable(hi_q));
      // R4
      hi_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync && tick && lo_q == '1) |=> hi_q == HALF_W'($past(hi_q) + 1'b1));
      // R1
      chain_sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sync |=> (lo_q == '0 && hi_q == '0 && link_q));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      hold_q   <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        case (rd_sel)
          2'd0: begin
            rd_data <= {{HALF_W{1'b0}}, now_val[HALF_W-1:0]};
            hold_q  <= now_val[FULL_W-1:HALF_W];
          end
          2'd1:    rd_data <= {{HALF_W{1'b0}}, hold_q};
          default: rd_data <= now_val;
        endcase
      end
    end
  end

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !sync) |=> $stable(now_val));
  // R6
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  // R6
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  // R7
  held_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_sel == 2'd1) |=> rd_data == {{HALF_W{1'b0}}, $past(hold_q)});
endmodule

// File: tb/tb_cascade_timebase.sv
`timescale 1ns/1ps
module tb_cascade_timebase;
  localparam int W  = 4;
  localparam int FW = 2 * W;
  localparam int MODV = 1 << FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync = 1'b0;
  logic [1:0] psel = 2'd0;
  logic rd_req = 1'b0;
  logic [1:0] rd_sel = 2'd2;
  logic rd_valid, rd_valid_w, link_o, link_w;
  logic [FW-1:0] rd_data, rd_data_w;

  int total = 0;
  int bad = 0;
  int k = 0;
  int dv = 2;

  always #2 clk = ~clk;

  cascade_timebase #(.HALF_W(W), .PSEL_W(2), .WIDE(1'b0)) dut (
    .clk(clk), .rst(rst), .sync(sync), .psel(psel), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data), .link_o(link_o));

  cascade_timebase #(.HALF_W(W), .PSEL_W(2), .WIDE(1'b1)) dut_w (
    .clk(clk), .rst(rst), .sync(sync), .psel(psel), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_valid(rd_valid_w), .rd_data(rd_data_w), .link_o(link_w));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    k++;
  endtask

  task automatic do_sync();
    sync = 1'b1;
    step();
    sync = 1'b0;
    k = 0;
  endtask

  function automatic int expect_cnt(input int edges);
    return (edges / dv) % MODV;
  endfunction

  task automatic read_both(input logic [1:0] sel, output int a, output int b);
    rd_sel = sel;
    rd_req = 1'b1;
    step();
    rd_req = 1'b0;
    check("R6 valid chained", int'(rd_valid), 1);
    check("R6 valid wide", int'(rd_valid_w), 1);
    a = int'(rd_data);
    b = int'(rd_data_w);
  endtask

  task automatic check_full(input string tag);
    int kk, a, b, e;
    kk = k;
    read_both(2'd2, a, b);
    e = expect_cnt(kk);
    check({tag, " chained"}, a, e);
    check({tag, " R8 wide"}, b, e);
    e = expect_cnt(k);
    check("R3 link chained", int'(link_o), ((e % (1 << W)) >> (W - 1)) == 0 ? 1 : 0);
    check("R8 link wide", int'(link_w), 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, b, kk, up_e, lo_e;
    repeat (3) step();
    // R1 reset state
    check("R1 link after reset", int'(link_o), 1);
    check("R8 link after reset", int'(link_w), 0);
    rst = 1'b0;
    k = 0;
    psel = 2'd0;
    dv = 2;
    check_full("R1 reset value");

    // R2 R4 R9 sweep every prescaler setting across a full wrap
    for (int s = 0; s < 4; s++) begin
      psel = 2'(s);
      dv = 2 << (2 * s);
      do_sync();
      check_full("R1 after sync");
      while (k < dv * (MODV + 20)) begin
        for (int j = 0; j < (dv * 3) + s; j++) step();
        check_full("R2 R4 sweep");
      end
      // R9: exact wrap back to zero
      do_sync();
      while (k < dv * MODV) step();
      check_full("R9 wrap to zero");
    end

    // R2 tick boundary with psel=1 (DIV 8)
    psel = 2'd1;
    dv = 8;
    do_sync();
    while (k < 7) step();
    check_full("R2 before first tick");
    while (k < 8) step();
    check_full("R2 at first tick");

    // R7 capture: low read latches upper, upper read later returns capture
    psel = 2'd0;
    dv = 2;
    do_sync();
    while (k < 2 * 37) step();
    kk = k;
    read_both(2'd0, a, b);
    lo_e = expect_cnt(kk) % (1 << W);
    up_e = expect_cnt(kk) / (1 << W);
    check("R7 low half chained", a, lo_e);
    check("R7 low half wide", b, lo_e);
    for (int j = 0; j < 2 * 40; j++) step();
    read_both(2'd1, a, b);
    check("R7 captured upper chained", a, up_e);
    check("R7 captured upper wide", b, up_e);
    check_full("R6 full after capture");

    // R5 sync mid-run
    psel = 2'd2;
    dv = 32;
    do_sync();
    for (int j = 0; j < 1000; j++) step();
    check_full("R5 before resync");
    do_sync();
    check_full("R5 right after resync");
    check("R5 link after resync", int'(link_o), 1);
    for (int j = 0; j < 95; j++) step();
    check_full("R5 counting after resync");

    // R6 code 3 aliases full read
    kk = k;
    read_both(2'd3, a, b);
    check("R6 sel3 chained", a, expect_cnt(kk));
    check("R6 sel3 wide", b, expect_cnt(kk));

    step();
    check("R6 valid drops", int'(rd_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule